// File: doc/BRIEF.md
# Four-Channel TDM PCM Serial Port

This block moves 8-bit voice samples between four codec channels and one shared serial PCM highway. Everything runs on the master bit clock `clk`. Transmit bits change on the rising edge and receive bits are sampled on the falling edge. The sign bit (MSB) goes first in both directions. Each bit period (one clock cycle) is called a cell.

There are two framing modes. In per-channel mode, every channel has its own transmit and receive frame sync, and all channels use the same sync format. The format is either short (a one-cell pulse ahead of the slot) or long (a pulse at least three cells wide that rises at the start of the slot). In consecutive mode, one short pulse on channel 0's syncs opens 32 cells that carry channels 0 to 3 in order. Two carry-out pulses then mark the 32nd cell so that a second port can be chained after this one.

The port drives a data-output enable and an active-low slot indicator. A powered-down channel keeps the line released in its slot and ignores the incoming data. Loopback sends a channel's last received byte back out in its own transmit slot.

Each channel has one transmit slot engine and one receive slot engine. Each engine is a two-state machine:
- `SLOT_IDLE` moves to `SLOT_SHIFT` on a start. The start comes from the frame sync, or in consecutive mode from the previous channel finishing.
- `SLOT_SHIFT` restarts on a new start.
- `SLOT_SHIFT` returns to `SLOT_IDLE` after its last bit.

Top module: `pcm_tdm_port`

## Requirements
- R1: Short transmit sync. If `fsx_in[i]` is high at the falling edge of cell k, the byte is driven in cells k+1..k+8, MSB first, with `dx_oe` high. The line is released at the rising edge that starts cell k+9.
- R2: Short receive sync. If `fsr_in[i]` is high at the falling edge of cell k, `dr` is latched at the falling edges of cells k+1..k+8, MSB first. `rx_valid[i]` is high for one cycle, seen in cell k+9. The byte then sits in `rx_data[8i+7:8i]`.
- R3: Long transmit sync (`long_frame`=1). If `fsx_in[i]` rises after the rising edge that starts cell s, the sign bit is driven within cell s itself. The remaining seven bits follow in cells s+1..s+7, and the line is released when cell s+8 starts.
- R4: Long receive sync. If `fsr_in[i]` rises after the rising edge that starts cell s, the sign bit is latched at the falling edge of cell s, and the slot lasts 8 cells. Strobe and data follow the timing of R2.
- R5: Consecutive mode (`mode32`=1). A short pulse on `fsx_in[0]`/`fsr_in[0]` starts 32 back-to-back cells: channel 0 in the first 8, then channels 1, 2 and 3. In this mode `fsx_in[3:1]`, `fsr_in[3:1]` and `long_frame` have no effect.
- R6: `fsx_carry` and `fsr_carry` each go high for exactly the 32nd cell of a consecutive frame. They stay low in per-channel mode and after reset.
- R7: A channel with `pd[i]`=1 leaves `dx_oe` low in its slot and produces no `rx_valid[i]`. Its `rx_data` byte is unchanged. Slot timing, chaining and the carries are not affected.
- R8: `tsx_n` is low in exactly the cells in which `dx_oe` is high.
- R9: With `loop[i]`=1, channel i transmits the most recent byte it received while it was powered up, in place of `tx_data[8i+7:8i]`.
- R10: While reset is held, `dx_oe`=0, `tsx_n`=1, both carries are 0, `rx_valid`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode32 | input | 1 | 1 selects consecutive 32-bit mode, 0 selects per-channel mode |
| long_frame | input | 1 | Per-channel mode sync format: 1 long, 0 short |
| pd | input | 4 | Per-channel power-down |
| loop | input | 4 | Per-channel digital loopback |
| fsx_in | input | 4 | Transmit frame syncs; only bit 0 is used in consecutive mode |
| fsr_in | input | 4 | Receive frame syncs; only bit 0 is used in consecutive mode |
| tx_data | input | 32 | Transmit bytes, channel i in bits 8i+7:8i |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data, valid while dx_oe is high |
| dx_oe | output | 1 | Output-buffer enable for dx |
| tsx_n | output | 1 | Slot indicator, active low |
| fsx_carry | output | 1 | Transmit carry-out frame pulse |
| fsr_carry | output | 1 | Receive carry-out frame pulse |
| rx_data | output | 32 | Received bytes, channel i in bits 8i+7:8i |
| rx_valid | output | 4 | One-cycle strobe per channel when a byte completes |

## Verification
The assertions assume the following about the inputs:
- Slots of different channels never overlap in per-channel mode.
- `pd` only changes between frames, so a strobe never coincides with a power-down edge.
- Frame syncs and `dr` change only shortly after a rising edge, so "rose since the last rising edge" has a single meaning.

The bench keeps within these limits. It changes all inputs 2 ns after a rising edge, spaces per-channel slots 9 cells apart inside 40-cell frames, and changes mode, power-down and loopback settings only at frame boundaries, once every engine is idle.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // Shared state encoding for the transmit and receive slot engines.
    typedef enum logic {
        SLOT_IDLE  = 1'b0,
        SLOT_SHIFT = 1'b1
    } slot_state_e;

endpackage

// File: rtl/pcm_fsync_sense.sv
// Frame sync observer for one sync input.
// rise_neg: the input went from low to high between the last two falling edges.
// new_since_pos: the input is high now but was low at the last rising edge.
module pcm_fsync_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic fs,
    output logic rise_neg,
    output logic new_since_pos
);

    logic neg_q;
    logic neg_qq;
    logic pos_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            neg_qq <= 1'b0;
        end else begin
            neg_q  <= fs;
            neg_qq <= neg_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= 1'b0;
        else        pos_q <= fs;
    end

    assign rise_neg      = neg_q & ~neg_qq;
    assign new_since_pos = fs & ~pos_q;

endmodule

// File: rtl/pcm_tx_slot.sv
// Transmit slot engine, rising-edge domain.
// start_full loads the byte and shows the sign bit in the coming cell.
// start_late loads the byte and continues at the next bit, because the
// sign bit was already shown combinationally in the previous cell.
module pcm_tx_slot
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_full,
    input  logic                start_late,
    input  logic [SAMPLE_W-1:0] byte_in,
    output logic                cur_bit,
    output logic                active,
    output logic                last
);

    localparam int IDX_W = $clog2(SAMPLE_W);

    slot_state_e         state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [SAMPLE_W-1:0] sh_q;
    logic                any_start;

    assign any_start = start_full | start_late;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE:  if (any_start) state_d = SLOT_SHIFT;
            SLOT_SHIFT: begin
                if (any_start)          state_d = SLOT_SHIFT;
                else if (idx_q == '0)   state_d = SLOT_IDLE;
            end
            default:    state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            sh_q  <= '0;
        end else if (start_full) begin
            sh_q  <= byte_in;
            idx_q <= IDX_W'(SAMPLE_W - 1);
        end else if (start_late) begin
            sh_q  <= byte_in;
            idx_q <= IDX_W'(SAMPLE_W - 2);
        end else if (state_q == SLOT_SHIFT && idx_q != '0) begin
            idx_q <= idx_q - 1'b1;
        end
    end

    assign active  = (state_q == SLOT_SHIFT);
    assign last    = active && (idx_q == '0);
    assign cur_bit = sh_q[idx_q];

endmodule

// File: rtl/pcm_rx_slot.sv
// Receive slot engine, falling-edge domain.
// start latches the sign bit at this falling edge.
module pcm_rx_slot
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                dr,
    input  logic                en,
    output logic [SAMPLE_W-1:0] byte_out,
    output logic                valid,
    output logic                done,
    output logic                near_end
);

    localparam int IDX_W = $clog2(SAMPLE_W);

    slot_state_e         state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [SAMPLE_W-1:0] sh_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE:  if (start) state_d = SLOT_SHIFT;
            SLOT_SHIFT: begin
                if (start)              state_d = SLOT_SHIFT;
                else if (idx_q == '0)   state_d = SLOT_IDLE;
            end
            default:    state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            sh_q     <= '0;
            byte_out <= '0;
            valid    <= 1'b0;
            done     <= 1'b0;
        end else begin
            valid <= 1'b0;
            done  <= 1'b0;
            if (start) begin
                sh_q  <= {sh_q[SAMPLE_W-2:0], dr};
                idx_q <= IDX_W'(SAMPLE_W - 2);
            end else if (state_q == SLOT_SHIFT) begin
                sh_q <= {sh_q[SAMPLE_W-2:0], dr};
                if (idx_q == '0) begin
                    done <= 1'b1;
                    if (en) begin
                        byte_out <= {sh_q[SAMPLE_W-2:0], dr};
                        valid    <= 1'b1;
                    end
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    assign near_end = (state_q == SLOT_SHIFT) && (idx_q == '0);

endmodule

// File: rtl/pcm_tdm_port.sv
// Four-channel TDM PCM serial port: per-channel or consecutive framing,
// carry-out pulses, power-down gating and digital loopback.
module pcm_tdm_port #(
    parameter int CHANNELS = 4,
    parameter int SAMPLE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode32,
    input  logic                         long_frame,
    input  logic [CHANNELS-1:0]          pd,
    input  logic [CHANNELS-1:0]          loop,
    input  logic [CHANNELS-1:0]          fsx_in,
    input  logic [CHANNELS-1:0]          fsr_in,
    input  logic [CHANNELS*SAMPLE_W-1:0] tx_data,
    input  logic                         dr,
    output logic                         dx,
    output logic                         dx_oe,
    output logic                         tsx_n,
    output logic                         fsx_carry,
    output logic                         fsr_carry,
    output logic [CHANNELS*SAMPLE_W-1:0] rx_data,
    output logic [CHANNELS-1:0]          rx_valid
);

    localparam int LAST = CHANNELS - 1;

    logic [CHANNELS-1:0] fsx_rise, fsx_new, fsr_rise, fsr_new;
    logic [CHANNELS-1:0] tx_start_full, tx_start_late, tx_active, tx_last, tx_bit;
    logic [CHANNELS-1:0] first_cell, drive_oe, drive_bit;
    logic [CHANNELS-1:0] rx_start, rx_done, rx_near;
    logic                fsr_carry_q;
    logic                spare_unused;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
        logic [SAMPLE_W-1:0] rx_byte;
        logic [SAMPLE_W-1:0] src_byte;

        pcm_fsync_sense u_fsx (
            .clk           (clk),
            .rst_n         (rst_n),
            .fs            (fsx_in[g]),
            .rise_neg      (fsx_rise[g]),
            .new_since_pos (fsx_new[g])
        );

        pcm_fsync_sense u_fsr (
            .clk           (clk),
            .rst_n         (rst_n),
            .fs            (fsr_in[g]),
            .rise_neg      (fsr_rise[g]),
            .new_since_pos (fsr_new[g])
        );

        // Slot starts: the head channel opens the consecutive frame, the
        // others follow the channel before them.
        if (g == 0) begin : g_head
            assign tx_start_full[g] = mode32 ? fsx_rise[g] : (~long_frame & fsx_rise[g]);
            assign rx_start[g]      = mode32 ? fsr_rise[g]
                                             : (long_frame ? fsr_new[g] : fsr_rise[g]);
        end else begin : g_chain
            assign tx_start_full[g] = mode32 ? tx_last[g-1] : (~long_frame & fsx_rise[g]);
            assign rx_start[g]      = mode32 ? rx_done[g-1]
                                             : (long_frame ? fsr_new[g] : fsr_rise[g]);
        end

        assign tx_start_late[g] = ~mode32 & long_frame & fsx_new[g];
        assign first_cell[g]    = ~mode32 & long_frame & fsx_new[g];
        assign src_byte         = loop[g] ? rx_byte : tx_data[g*SAMPLE_W +: SAMPLE_W];

        pcm_tx_slot #(.SAMPLE_W(SAMPLE_W)) u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_full (tx_start_full[g]),
            .start_late (tx_start_late[g]),
            .byte_in    (src_byte),
            .cur_bit    (tx_bit[g]),
            .active     (tx_active[g]),
            .last       (tx_last[g])
        );

        pcm_rx_slot #(.SAMPLE_W(SAMPLE_W)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (rx_start[g]),
            .dr       (dr),
            .en       (~pd[g]),
            .byte_out (rx_byte),
            .valid    (rx_valid[g]),
            .done     (rx_done[g]),
            .near_end (rx_near[g])
        );

        assign drive_oe[g]  = ~pd[g] & (tx_active[g] | first_cell[g]);
        assign drive_bit[g] = tx_active[g] ? tx_bit[g] : src_byte[SAMPLE_W-1];
        assign rx_data[g*SAMPLE_W +: SAMPLE_W] = rx_byte;
    end

    // Receive carry is aligned to the cell in which the last channel
    // takes its final bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsr_carry_q <= 1'b0;
        else        fsr_carry_q <= mode32 & rx_near[LAST];
    end

    assign fsx_carry = mode32 & tx_last[LAST];
    assign fsr_carry = fsr_carry_q;
    assign dx_oe     = |drive_oe;
    assign dx        = |(drive_oe & drive_bit);
    assign tsx_n     = ~dx_oe;

    assign spare_unused = ^{rx_done[LAST], rx_near[LAST-1:0]};

endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk #(
    parameter int CHANNELS = 4,
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CHANNELS-1:0] pd,
    input logic                dx_oe,
    input logic                fsx_carry,
    input logic                fsr_carry,
    input logic [CHANNELS-1:0] rx_valid
);

    localparam int RUN_MAX = CHANNELS * SAMPLE_W;
    localparam int RW      = $clog2(RUN_MAX + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           run_q <= '0;
        else if (!dx_oe)                      run_q <= '0;
        else if (run_q <= RW'(RUN_MAX))       run_q <= run_q + 1'b1;
    end

    // R5: no drive window is longer than one full consecutive frame
    assert_drive_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(RUN_MAX));

    // R6: carries are one cell wide
    assert_fsx_carry_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fsx_carry |=> !fsx_carry);
    assert_fsr_carry_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fsr_carry |=> !fsr_carry);

    // R2: receive strobes last one cycle and never coincide
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid != '0) |=> (rx_valid == '0));
    assert_valid_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_valid));

    // R7: powered-down channels neither strobe nor drive
    assert_pd_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid & pd) == '0);
    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&pd) |-> !dx_oe);

endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(
    .CHANNELS (CHANNELS),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd        (pd),
    .dx_oe     (dx_oe),
    .fsx_carry (fsx_carry),
    .fsr_carry (fsr_carry),
    .rx_valid  (rx_valid)
);

// File: tb/tb_pcm_tdm_port.sv
module tb_pcm_tdm_port;

    localparam int NCELL = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode32 = 1'b0;
    logic        long_frame = 1'b0;
    logic [3:0]  pd = '0;
    logic [3:0]  loop = '0;
    logic [3:0]  fsx_in = '0;
    logic [3:0]  fsr_in = '0;
    logic [31:0] tx_data = '0;
    logic        dr = 1'b0;
    logic        dx, dx_oe, tsx_n, fsx_carry, fsr_carry;
    logic [31:0] rx_data;
    logic [3:0]  rx_valid;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rx_hist [4] = '{default: 8'h00};

    pcm_tdm_port dut (
        .clk(clk), .rst_n(rst_n), .mode32(mode32), .long_frame(long_frame),
        .pd(pd), .loop(loop), .fsx_in(fsx_in), .fsr_in(fsr_in),
        .tx_data(tx_data), .dr(dr), .dx(dx), .dx_oe(dx_oe), .tsx_n(tsx_n),
        .fsx_carry(fsx_carry), .fsr_carry(fsr_carry),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic run_frame(input bit m32, input bit lng, input logic [3:0] pdv,
                             input logic [3:0] lpv, input logic [31:0] txv,
                             input logic [31:0] rxv);
        int st [4];
        logic [7:0] txb [4];
        logic [7:0] rxb [4];
        for (int i = 0; i < 4; i++) begin
            st[i]  = m32 ? 2 + 8 * i : 2 + 9 * i;
            txb[i] = lpv[i] ? rx_hist[i] : txv[i*8 +: 8];
            rxb[i] = rxv[i*8 +: 8];
        end
        for (int c = 0; c < NCELL; c++) begin
            logic eoe, ebit;
            logic [3:0] ev;
            string ttag;
            @(posedge clk);
            #2;
            if (c == 0) begin
                mode32 = m32; long_frame = lng; pd = pdv; loop = lpv; tx_data = txv;
            end
            fsx_in = '0; fsr_in = '0; dr = 1'b0;
            if (m32) begin
                if (c == st[0] - 1) begin fsx_in[0] = 1'b1; fsr_in[0] = 1'b1; end
                if (c == 5 || c == 17) begin fsx_in[3:1] = 3'b111; fsr_in[3:1] = 3'b111; end
            end else begin
                for (int i = 0; i < 4; i++) begin
                    if (lng ? (c >= st[i] && c < st[i] + 3) : (c == st[i] - 1)) begin
                        fsx_in[i] = 1'b1; fsr_in[i] = 1'b1;
                    end
                end
            end
            for (int i = 0; i < 4; i++)
                if (c >= st[i] && c < st[i] + 8) dr = rxb[i][7 - (c - st[i])];
            #3;
            eoe = 1'b0; ebit = 1'b0; ev = '0; ttag = lng ? "R3" : "R1";
            for (int i = 0; i < 4; i++) begin
                if (c >= st[i] && c < st[i] + 8) begin
                    ttag = pdv[i] ? "R7" : (lpv[i] ? "R9" : (m32 ? "R5" : (lng ? "R3" : "R1")));
                    if (!pdv[i]) begin
                        eoe  = 1'b1;
                        ebit = txb[i][7 - (c - st[i])];
                    end
                end
                if (!pdv[i] && c == st[i] + 8) ev[i] = 1'b1;
            end
            chk(ttag, {31'd0, dx_oe}, {31'd0, eoe});
            chk("R8", {31'd0, tsx_n}, {31'd0, ~eoe});
            if (eoe) chk(ttag, {31'd0, dx}, {31'd0, ebit});
            chk("R6", {30'd0, fsx_carry, fsr_carry},
                (m32 && c == st[0] + 31) ? 32'd3 : 32'd0);
            chk(m32 ? "R5" : (lng ? "R4" : "R2"), {28'd0, rx_valid}, {28'd0, ev});
            for (int i = 0; i < 4; i++)
                if (ev[i]) chk(lng && !m32 ? "R4" : "R2", {24'd0, rx_data[i*8 +: 8]}, {24'd0, rxb[i]});
        end
        for (int i = 0; i < 4; i++) if (!pdv[i]) rx_hist[i] = rxb[i];
        chk("R7", rx_data, {rx_hist[3], rx_hist[2], rx_hist[1], rx_hist[0]});
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog R10: actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R10: reset state
        chk("R10", {29'd0, dx_oe, fsx_carry, fsr_carry}, 32'd0);
        chk("R10", {31'd0, tsx_n}, 32'd1);
        chk("R10", {28'd0, rx_valid}, 32'd0);
        chk("R10", rx_data, 32'd0);
        @(posedge clk); #2; rst_n = 1'b1;

        run_frame(1'b0, 1'b0, 4'b0000, 4'b0000, 32'hA53C_96E1, 32'h5AC3_0F81); // R1 R2
        run_frame(1'b0, 1'b1, 4'b0000, 4'b0000, 32'h1E2D_3C4B, 32'hF00F_81C7); // R3 R4
        run_frame(1'b0, 1'b0, 4'b0010, 4'b0000, 32'h7788_99AA, 32'h1234_5678); // R7
        run_frame(1'b0, 1'b0, 4'b0000, 4'b0101, 32'h0000_0000, 32'hDEAD_BEEF); // R9
        run_frame(1'b0, 1'b1, 4'b0001, 4'b1010, 32'hFFFF_FFFF, 32'h6B5A_4938); // R3 R7 R9
        run_frame(1'b1, 1'b0, 4'b0000, 4'b0000, 32'hC3A5_5A3C, 32'h8142_2418); // R5 R6
        run_frame(1'b1, 1'b1, 4'b1111, 4'b0000, 32'hFFFF_FFFF, 32'hAAAA_5555); // R5 R6 R7
        run_frame(1'b1, 1'b0, 4'b0100, 4'b1001, 32'h0F0F_0F0F, 32'h9C8B_7A69); // R5 R9
        for (int k = 0; k < 8; k++)
            run_frame(k[0], k[1], 4'($urandom()), 4'($urandom()), $urandom(), $urandom());
        run_frame(1'b0, 1'b0, 4'b0000, 4'b0000, 32'h0102_0408, 32'h1020_4080); // R1 R8

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule